// File: doc/BRIEF.md
# Serial Configuration Chain Receiver

This block is the configuration port of a device that loads in slave-serial fashion. An outside source drives one bit per cycle on `din`. The port samples that bit on each rising edge of the externally supplied configuration clock `cfg_clk`. The port takes in bits until it has its own bitstream, whose length is set by the parameter `BIT_LEN`. From then on it passes every later bit to `dout`, so the next device in a daisy chain can load from the same source.

The mode is decoded from three select inputs. Data is accepted only after the ready indication `init_ready` has come back up. The ready indication goes low whenever the active-low program input is pulled low, and stays low for `INIT_HOLD` cycles after the program input is released. For checking, the captured bits are also grouped into parallel words with a one-cycle valid strobe.

Top module: `serial_cfg_chain`

## Requirements
- R1: After reset, `init_ready` is 0, `cfg_done` is 0, `dout` is 1 and `word_vld` is 0.
- R2: A rising edge that samples `prog_n` low clears the bit count and `cfg_done`, sets `dout` to 1 and drops `init_ready`. `init_ready` rises again after exactly `INIT_HOLD` rising edges that sample `prog_n` high.
- R3: The port is in slave mode when `mode_sel[1:0]` is 2'b11, that is 3'b111 or 3'b011. In any other mode, `din` is ignored: no bit is counted, no word is strobed and nothing is forwarded, so `dout` is 1.
- R4: While `init_ready` is 0, `din` is ignored and the bit count does not move.
- R5: Exactly one bit is taken per rising edge. `cfg_done` rises on the edge that captures the `BIT_LEN`-th accepted bit, not one edge earlier. It stays high until `prog_n` is sampled low or reset is applied.
- R6: While `cfg_done` is 0, `dout` is held at 1.
- R7: Once `cfg_done` is 1 in slave mode, `dout` takes the value of `din` sampled at each rising edge, one edge after that bit is presented. Leaving slave mode returns `dout` to 1.
- R8: Own bits are packed into `WORD_W`-bit words, with the first received bit in the MSB. `word_vld` pulses for one cycle after the edge that captures the last bit of each full word. A partial final word is never strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration clock; data is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| prog_n | input | 1 | Active-low program request; restarts the load |
| mode_sel | input | 3 | Mode select; slave mode when bits [1:0] are 2'b11 |
| din | input | 1 | Serial configuration data in |
| dout | output | 1 | Daisy-chain serial data out; 1 until forwarding |
| init_ready | output | 1 | High when the port can accept data |
| cfg_done | output | 1 | High once the own bitstream is complete |
| word_out | output | WORD_W | Last full word of own bits, first bit in MSB |
| word_vld | output | 1 | One-cycle strobe for `word_out` |

## Verification
The bench goes after the boundary at the last own bit. A counter that is off by one would raise `cfg_done` an edge early or late, and would either forward the last own bit or swallow the first forwarded one. The scoreboard would then see a wrong `dout` value.

Bits sent during the ready hold window and bits sent in the non-slave modes 3'b010 and 3'b110 must leave no trace. A design that counted them would finish early. A design that packed them would strobe a word the scoreboard never expected.

`BIT_LEN` is chosen so that the last word is partial. A packer that flushed the partial word would raise a stray strobe.

A program pulse in the middle of forwarding must drop `cfg_done` and return `dout` to 1. A design that kept forwarding after that pulse would fail the per-cycle check of `dout`.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

  typedef enum logic [0:0] {
    PH_OWN  = 1'b0,
    PH_PASS = 1'b1
  } chain_phase_e;

  function automatic logic slave_sel(input logic [2:0] m);
    return m[1] & m[0];
  endfunction

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/cfg_init_timer.sv
module cfg_init_timer #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic prog_n,
  output logic ready
);
  localparam int unsigned HW = $clog2(HOLD + 1);

  logic [HW-1:0] hold_q, hold_d;
  logic          hold_en;

  always_comb begin
    hold_en = 1'b0;
    hold_d  = hold_q;
    if (!prog_n) begin
      hold_en = 1'b1;
      hold_d  = HW'(HOLD);
    end else if (hold_q != '0) begin
      hold_en = 1'b1;
      hold_d  = hold_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hold_q <= HW'(HOLD);
    else if (hold_en) hold_q <= hold_d;
  end

  assign ready = (hold_q == '0);
endmodule

// File: rtl/cfg_bit_counter.sv
module cfg_bit_counter import cfg_chain_pkg::*; #(
  parameter int unsigned BIT_LEN = 6519648,
  parameter int unsigned CNT_W   = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_n,
  input  logic             accept_en,
  output logic             take,
  output logic [CNT_W-1:0] bit_cnt,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BIT_LEN - 1);

  chain_phase_e     ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd_en;

  assign take = accept_en && prog_n && (ph_q == PH_OWN);

  always_comb begin
    upd_en = 1'b0;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    if (!prog_n) begin
      upd_en = 1'b1;
      ph_d   = PH_OWN;
      cnt_d  = '0;
    end else if (take) begin
      upd_en = 1'b1;
      cnt_d  = cnt_q + 1'b1;
      if (cnt_q == LAST) ph_d = PH_PASS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_OWN;
      cnt_q <= '0;
    end else if (upd_en) begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
    end
  end

  assign bit_cnt = cnt_q;
  assign done    = (ph_q == PH_PASS);
endmodule

// File: rtl/cfg_word_pack.sv
module cfg_word_pack #(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              take,
  input  logic              din,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld
);
  localparam int unsigned PW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [PW-1:0] POS_LAST = PW'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d, wd_q, wd_d;
  logic [PW-1:0]     pos_q, pos_d;
  logic              vld_q, vld_d;
  logic              sh_en, wd_en;

  always_comb begin
    sh_en = 1'b0;
    wd_en = 1'b0;
    sh_d  = sh_q;
    pos_d = pos_q;
    wd_d  = wd_q;
    vld_d = 1'b0;
    if (clr) begin
      sh_en = 1'b1;
      pos_d = '0;
    end else if (take) begin
      sh_en = 1'b1;
      sh_d  = {sh_q[WORD_W-2:0], din};
      if (pos_q == POS_LAST) begin
        pos_d = '0;
        wd_en = 1'b1;
        wd_d  = sh_d;
        vld_d = 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      pos_q <= '0;
    end else if (sh_en) begin
      sh_q  <= sh_d;
      pos_q <= pos_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     wd_q <= '0;
    else if (wd_en) wd_q <= wd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign word_out = wd_q;
  assign word_vld = vld_q;
endmodule

// File: rtl/serial_cfg_chain.sv
module serial_cfg_chain import cfg_chain_pkg::*; #(
  parameter int unsigned BIT_LEN   = 6519648,
  parameter int unsigned INIT_HOLD = 16,
  parameter int unsigned WORD_W    = 32
) (
  input  logic              cfg_clk,
  input  logic              rst_n,
  input  logic              prog_n,
  input  logic [2:0]        mode_sel,
  input  logic              din,
  output logic              dout,
  output logic              init_ready,
  output logic              cfg_done,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld
);
  localparam int unsigned CNT_W = $clog2(BIT_LEN + 1);

  logic             rst_i_n;
  logic             slave_en;
  logic             take;
  logic [CNT_W-1:0] bit_cnt;
  logic             dout_q, dout_d;

  assign slave_en = slave_sel(mode_sel);

  cfg_rst_sync u_rst (
    .clk        (cfg_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cfg_init_timer #(.HOLD(INIT_HOLD)) u_timer (
    .clk    (cfg_clk),
    .rst_n  (rst_i_n),
    .prog_n (prog_n),
    .ready  (init_ready)
  );

  cfg_bit_counter #(.BIT_LEN(BIT_LEN), .CNT_W(CNT_W)) u_cnt (
    .clk       (cfg_clk),
    .rst_n     (rst_i_n),
    .prog_n    (prog_n),
    .accept_en (init_ready & slave_en),
    .take      (take),
    .bit_cnt   (bit_cnt),
    .done      (cfg_done)
  );

  cfg_word_pack #(.WORD_W(WORD_W)) u_pack (
    .clk      (cfg_clk),
    .rst_n    (rst_i_n),
    .clr      (~prog_n),
    .take     (take),
    .din      (din),
    .word_out (word_out),
    .word_vld (word_vld)
  );

  always_comb begin
    dout_d = 1'b1;
    if (cfg_done && slave_en && prog_n) dout_d = din;
  end

  always_ff @(posedge cfg_clk or negedge rst_i_n) begin
    if (!rst_i_n) dout_q <= 1'b1;
    else          dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/serial_cfg_chain_chk.sv
module serial_cfg_chain_chk #(
  parameter int unsigned BIT_LEN = 8,
  parameter int unsigned CNT_W   = 4
) (
  input logic             cfg_clk,
  input logic             rst_n,
  input logic             prog_n,
  input logic             din,
  input logic             dout,
  input logic             init_ready,
  input logic             cfg_done,
  input logic             word_vld,
  input logic             slave_en,
  input logic [CNT_W-1:0] bit_cnt
);
  // R2
  prog_clear_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !prog_n |=> (!init_ready && !cfg_done && dout));

  // R3
  nonslave_ignore_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (!slave_en && prog_n) |=> ($stable(bit_cnt) && !word_vld));

  // R4
  not_ready_ignore_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (!init_ready && prog_n) |=> ($stable(bit_cnt) && !word_vld));

  // R5
  done_sticky_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_done && prog_n) |=> cfg_done);

  // R5
  done_at_last_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    $rose(cfg_done) |-> ($past(bit_cnt) == CNT_W'(BIT_LEN - 1)));

  // R6
  dout_idle_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    !cfg_done |-> dout);

  // R7
  forward_chk: assert property (@(posedge cfg_clk) disable iff (!rst_n)
    (cfg_done && slave_en && prog_n) |=> (dout == $past(din)));
endmodule

bind serial_cfg_chain serial_cfg_chain_chk #(
  .BIT_LEN (BIT_LEN),
  .CNT_W   (CNT_W)
) u_chk (
  .cfg_clk    (cfg_clk),
  .rst_n      (rst_n),
  .prog_n     (prog_n),
  .din        (din),
  .dout       (dout),
  .init_ready (init_ready),
  .cfg_done   (cfg_done),
  .word_vld   (word_vld),
  .slave_en   (slave_en),
  .bit_cnt    (bit_cnt)
);

// File: tb/serial_cfg_chain_tb_top.sv
module serial_cfg_chain_tb_top;
  localparam int unsigned BIT_LEN   = 80;
  localparam int unsigned INIT_HOLD = 4;
  localparam int unsigned WORD_W    = 32;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              prog_n;
  logic [2:0]        mode_sel;
  logic              din;
  logic              dout;
  logic              init_ready;
  logic              cfg_done;
  logic [WORD_W-1:0] word_out;
  logic              word_vld;

  int vecs = 0;
  int miss = 0;

  logic [WORD_W-1:0] word_q[$];
  logic              fwd_q[$];

  logic              slave_tb;
  logic              rdy_tb;
  int                own_cnt;
  logic [WORD_W-1:0] shacc;
  logic [15:0]       lf;

  always #10 clk = ~clk;

  serial_cfg_chain #(
    .BIT_LEN(BIT_LEN), .INIT_HOLD(INIT_HOLD), .WORD_W(WORD_W)
  ) dut_i (
    .cfg_clk(clk), .rst_n(rst_n), .prog_n(prog_n), .mode_sel(mode_sel),
    .din(din), .dout(dout), .init_ready(init_ready), .cfg_done(cfg_done),
    .word_out(word_out), .word_vld(word_vld)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic next_bit();
    logic b;
    b  = lf[0];
    lf = {lf[0] ^ lf[2] ^ lf[3] ^ lf[5], lf[15:1]};
    return b;
  endfunction

  // Driver: called at a negedge, returns at the next negedge.
  task automatic send_bit(input logic b);
    logic acc;
    logic fwd;
    din = b;
    acc = slave_tb && rdy_tb && (own_cnt < BIT_LEN);
    fwd = slave_tb && (own_cnt == BIT_LEN);
    fwd_q.push_back(fwd ? b : 1'b1);
    if (acc) begin
      shacc = {shacc[WORD_W-2:0], b};
      own_cnt++;
      if (own_cnt % WORD_W == 0) word_q.push_back(shacc);
    end
    @(negedge clk);
  endtask

  // Program pulse with hold window; din toggles, nothing may be taken.
  task automatic do_prog();
    prog_n = 1'b0;
    din = next_bit();
    @(negedge clk);
    chk("R2 ready low", init_ready, 0);
    chk("R2 done clear", cfg_done, 0);
    chk("R2 dout high", dout, 1);
    prog_n = 1'b1;
    own_cnt = 0;
    rdy_tb = 1'b0;
    for (int i = 0; i < INIT_HOLD - 1; i++) begin
      din = next_bit();
      @(negedge clk);
    end
    chk("R2 ready still low", init_ready, 0);
    din = next_bit();
    @(negedge clk);
    chk("R2 ready high", init_ready, 1);
    rdy_tb = 1'b1;
  endtask

  task automatic load_own();
    for (int i = 0; i < BIT_LEN; i++) begin
      send_bit(next_bit());
      if (i == BIT_LEN - 2) chk("R5 done not early", cfg_done, 0);
      if (i < BIT_LEN - 1) chk("R6 dout held high", dout, 1);
    end
    chk("R5 done at last bit", cfg_done, 1);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (fwd_q.size() > 0) chk("R7 dout stream", dout, fwd_q.pop_front());
      if (word_vld) begin
        if (word_q.size() == 0) chk("R8 unexpected strobe", 1, 0);
        else chk("R8 word value", word_out, word_q.pop_front());
      end
    end
  end

  initial begin
    #(20 * 150000);
    miss++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    lf = 16'hACE1;
    shacc = '0;
    own_cnt = 0;
    rdy_tb = 1'b0;
    slave_tb = 1'b1;
    rst_n = 1'b0;
    prog_n = 1'b1;
    mode_sel = 3'b111;
    din = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 ready", init_ready, 0);
    chk("R1 done", cfg_done, 0);
    chk("R1 dout", dout, 1);
    chk("R1 word_vld", word_vld, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Load in mode 111, then forward
    do_prog();
    load_own();
    for (int i = 0; i < 40; i++) send_bit(next_bit());
    chk("R5 done sticky", cfg_done, 1);
    // Leave slave mode while forwarding: dout returns high
    mode_sel = 3'b010; slave_tb = 1'b0;
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    chk("R7 dout high off mode", dout, 1);
    mode_sel = 3'b111; slave_tb = 1'b1;
    for (int i = 0; i < 10; i++) send_bit(next_bit());

    // Program pulse mid-forwarding; then non-slave modes ignore data
    do_prog();
    mode_sel = 3'b010; slave_tb = 1'b0;
    for (int i = 0; i < 40; i++) send_bit(next_bit());
    mode_sel = 3'b110;
    for (int i = 0; i < 40; i++) send_bit(next_bit());
    chk("R3 no done in non-slave", cfg_done, 0);
    chk("R4 ready kept", init_ready, 1);
    // Mode 011 loads the full length from scratch
    mode_sel = 3'b011; slave_tb = 1'b1;
    load_own();
    for (int i = 0; i < 24; i++) send_bit(next_bit());
    chk("R8 queue drained", word_q.size(), 0);
    chk("R7 queue drained", fwd_q.size(), 0);

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule